// File: doc/BRIEF.md
# Terminator-to-Flag Packet Framing Adapter

This block joins two ready/valid byte streams that mark the end of a packet differently. On its input side a packet is closed by a separate terminator beat that carries no payload; on its output side the closing data beat itself carries a "last" flag. A beat cannot be flagged until the block knows what follows it, so the most recent data beat waits in a one-entry holding register. It is released with last clear when another data beat arrives, or with last set when a terminator arrives.

A "first" flag rides with each data beat and means "restart payload processing". It is stored with its beat and leaves with it, and it never closes a packet by itself. A terminator that finds nothing held closes an empty packet; it is absorbed and produces no output. The output side is a registered stage. A held beat can move into it in the same cycle that a new beat enters the holding register, so a continuous stream flows at one beat per clock with no bubble beyond the terminator beat itself.

Top module: `endlast_adapter`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising clock edge) empties the holding register and clears `out_valid`; right after reset `in_ready` is 1.
- R2: A data beat (`in_end`=0) accepted when nothing is held produces no output beat until a later beat is accepted.
- R3: A data beat accepted while a beat is held sends the held beat out with `out_last`=0 from the next cycle, and the new beat takes its place; beat order is preserved.
- R4: A terminator beat (`in_end`=1) accepted while a beat is held sends the held beat out with `out_last`=1 and leaves the holding register empty; `in_data` is ignored on a terminator beat.
- R5: A terminator beat accepted when nothing is held is consumed with `in_ready`=1 and produces no output beat.
- R6: `in_first` on a data beat appears as `out_first` on that same beat at the output; `out_first` never causes `out_last`; `in_first` on a terminator beat is ignored.
- R7: `in_ready` is 1 exactly when the holding register is empty, or `out_valid` is 0, or `out_ready` is 1.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data`, `out_first` and `out_last` hold their values into the next cycle.
- R9: With `in_valid` and `out_ready` held at 1, the block accepts one beat and emits one beat per cycle after the first two cycles of a packet.
- R10: The output beat sequence is the same under every pattern of `in_valid` and `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken this cycle |
| in_data | input | DATA_W | Input payload (ignored on terminator beats) |
| in_first | input | 1 | Restart flag of an input data beat |
| in_end | input | 1 | 1 marks a dataless terminator beat |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | DATA_W | Output payload |
| out_first | output | 1 | Restart flag carried with the beat |
| out_last | output | 1 | Beat is the final one of its packet |

## Verification
The main function is swept with a fixed packet script holding empty packets, single-beat packets, longer packets and a restart flag in mid-packet, under every non-zero pair of 4-cycle repeating patterns for `in_valid` and `out_ready`. Expected output beats are derived arithmetically by looking one input beat ahead, so any pattern-dependent loss, duplication or wrong last flag separates from the reference. Terminator beats are driven with junk data and a set restart flag to show both are dropped. Directed runs then pin the exact cycles of holdback, stall with a full pipeline, full-rate streaming and reset in mid-stream.

// File: rtl/elx_pkg.sv
// Package: shared types for the terminator-to-flag framing adapter.
// Assumes: nothing beyond IEEE 1800-2017.
package elx_pkg;

    // What one clock cycle does with the input side of the adapter.
    typedef enum logic [1:0] {
        STEP_IDLE  = 2'd0,   // no input beat accepted
        STEP_PUSH  = 2'd1,   // data beat accepted
        STEP_CLOSE = 2'd2,   // terminator accepted while a beat is held
        STEP_DROP  = 2'd3    // terminator accepted with nothing held
    } step_e;

endpackage

// File: rtl/elx_flow_ctrl.sv
// Module: elx_flow_ctrl
// Decides whether the input beat is taken and classifies the cycle.
// Assumes: the output stage frees up when it is empty or being drained.
module elx_flow_ctrl
    import elx_pkg::*;
(
    input  logic  in_valid,
    input  logic  in_end,
    input  logic  hold_v,
    input  logic  out_valid,
    input  logic  out_ready,
    output logic  in_ready,
    output step_e step
);

    logic out_free;
    logic take;

    // Acceptance rule: room exists if nothing is held or the held beat can move on.
    always_comb begin
        out_free = !out_valid || out_ready;
        in_ready = !hold_v || out_free;
        take     = in_valid && in_ready;
    end

    // Classify the accepted beat for the two storage stages.
    always_comb begin
        if (!take) begin
            step = STEP_IDLE;
        end else if (!in_end) begin
            step = STEP_PUSH;
        end else if (hold_v) begin
            step = STEP_CLOSE;
        end else begin
            step = STEP_DROP;
        end
    end

endmodule

// File: rtl/elx_hold_reg.sv
// Module: elx_hold_reg
// One-entry holding register for the newest data beat whose fate is unknown.
// Assumes: step was computed with the current hold_v.
module elx_hold_reg
    import elx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    output logic              hold_v,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_first
);

    // Capture each data beat; a terminator empties the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v     <= 1'b0;
            hold_data  <= '0;
            hold_first <= 1'b0;
        end else begin
            case (step)
                STEP_PUSH: begin
                    hold_v     <= 1'b1;
                    hold_data  <= in_data;
                    hold_first <= in_first;
                end
                STEP_CLOSE: hold_v <= 1'b0;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/elx_out_reg.sv
// Module: elx_out_reg
// Registered output stage; receives the held beat once its last flag is known.
// Assumes: flow control only lets the held beat in when this stage is free.
module elx_out_reg
    import elx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  logic              hold_v,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_first,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last
);

    logic load;

    // The held beat is released by any accepted data or terminator beat.
    always_comb begin
        load = hold_v && ((step == STEP_PUSH) || (step == STEP_CLOSE));
    end

    // Load a released beat, else drain the stage when downstream takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= hold_data;
            out_first <= hold_first;
            out_last  <= (step == STEP_CLOSE);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/endlast_adapter.sv
// Module: endlast_adapter (top)
// Converts packets closed by a dataless terminator beat into packets whose
// final data beat carries a last flag. One data beat is held back until the
// following beat shows whether it is final.
// Assumes: in_end=1 beats carry no payload; first is a restart marker only.
module endlast_adapter
    import elx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_end,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last
);

    step_e             step;
    logic              hold_v;
    logic [DATA_W-1:0] hold_data;
    logic              hold_first;

    elx_flow_ctrl u_flow (
        .in_valid  (in_valid),
        .in_end    (in_end),
        .hold_v    (hold_v),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .step      (step)
    );

    elx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .in_data    (in_data),
        .in_first   (in_first),
        .hold_v     (hold_v),
        .hold_data  (hold_data),
        .hold_first (hold_first)
    );

    elx_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .hold_v     (hold_v),
        .hold_data  (hold_data),
        .hold_first (hold_first),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_first  (out_first),
        .out_last   (out_last)
    );

endmodule

// File: rtl/endlast_adapter_chk.sv
// Module: endlast_adapter_chk
// Property checker bound to endlast_adapter; observes ports and hold state.
// Assumes: synchronous active-low reset.
module endlast_adapter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_end,
    input logic              in_first,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_first,
    input logic              out_last,
    input logic              hold_v,
    input logic              hold_first
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !hold_v));

    assert_hold_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_end && !hold_v && (!out_valid || out_ready))
        |=> (!out_valid && hold_v));

    assert_push_nolast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_end && hold_v) |=> (out_valid && !out_last && hold_v));

    assert_close_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_end && hold_v) |=> (out_valid && out_last && !hold_v));

    assert_empty_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_end && !hold_v && (!out_valid || out_ready))
        |=> (!out_valid && !hold_v));

    assert_first_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && hold_v) |=> (out_first == $past(hold_first)));

    assert_first_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_end) |=> (hold_first == $past(in_first)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v && out_valid && !out_ready) |-> !in_ready);

    assert_empty_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_v |-> in_ready);

    assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last)));

endmodule

bind endlast_adapter endlast_adapter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_end     (in_end),
    .in_first   (in_first),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_first  (out_first),
    .out_last   (out_last),
    .hold_v     (hold_v),
    .hold_first (hold_first)
);

// File: tb/endlast_adapter_test.sv
// Bench: pattern sweep plus directed cycle checks for endlast_adapter.
module endlast_adapter_test;

    localparam int DW  = 8;
    localparam int MAXS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_first = 1'b0;
    logic          in_end = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_first;
    logic          out_last;

    int n_checks = 0;
    int n_fails  = 0;
    int n_cycles = 0;
    bit finished = 1'b0;

    // script of input beats and expected output beats
    bit      sc_end   [MAXS];
    bit [7:0] sc_data [MAXS];
    bit      sc_first [MAXS];
    int      ns;
    bit [7:0] ex_data [MAXS];
    bit      ex_first [MAXS];
    bit      ex_last  [MAXS];
    int      ne;

    // sampled handshake results of the last step
    bit s_in_rdy, s_in_acc, s_ov, s_out_acc, s_of, s_ol;
    bit [7:0] s_od;

    endlast_adapter #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_end(in_end),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last)
    );

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) begin
        n_cycles <= n_cycles + 1;
        if (n_cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_fails  = n_fails + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", n_cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle at negedge, sample just before the next rising edge
    task automatic step(input bit v, input bit e, input bit [7:0] d, input bit f, input bit r);
        @(negedge clk);
        in_valid = v; in_end = e; in_data = d; in_first = f; out_ready = r;
        #3;
        s_in_rdy  = in_ready;
        s_in_acc  = in_valid && in_ready;
        s_ov      = out_valid;
        s_out_acc = out_valid && out_ready;
        s_od      = out_data;
        s_of      = out_first;
        s_ol      = out_last;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // packets of lengths 1,0,3,2,1,4; first on opening beats and mid-packet
    task automatic build_script();
        int lens [6] = '{1, 0, 3, 2, 1, 4};
        int k = 0;
        for (int p = 0; p < 6; p++) begin
            for (int b = 0; b < lens[p]; b++) begin
                sc_end[k]   = 1'b0;
                sc_data[k]  = 8'((k * 7 + 3) % 256);
                sc_first[k] = (b == 0) || (p == 5 && b == 2);
                k++;
            end
            sc_end[k]   = 1'b1;
            sc_data[k]  = 8'hEE;       // junk on terminator (R4)
            sc_first[k] = p[0];        // ignored flag on terminator (R6)
            k++;
        end
        ns = k;
        ne = 0;
        for (int i = 0; i + 1 < ns; i++) begin
            if (!sc_end[i]) begin
                ex_data[ne]  = sc_data[i];
                ex_first[ne] = sc_first[i];
                ex_last[ne]  = sc_end[i + 1];
                ne++;
            end
        end
    endtask

    initial begin
        int si, oi, cyc, outs;
        bit pst, pf, pl, allrdy, lastpos;
        bit [7:0] pd;

        build_script();

        // ---------- R1: reset state ----------
        do_reset();
        step(0, 0, 0, 0, 0);
        check(s_ov == 0, "R1 out_valid after reset", s_ov, 0);
        check(s_in_rdy == 1, "R1 in_ready after reset", s_in_rdy, 1);

        // ---------- R5 / R2: empty terminator and holdback ----------
        step(1, 1, 8'h55, 1, 1);
        check(s_in_rdy == 1, "R5 terminator taken on empty", s_in_rdy, 1);
        step(0, 0, 0, 0, 1);
        check(s_ov == 0, "R5 no beat from empty packet", s_ov, 0);
        step(1, 0, 8'hD1, 0, 1);
        step(0, 0, 0, 0, 1);
        check(s_ov == 0, "R2 held beat not sent (1)", s_ov, 0);
        step(0, 0, 0, 0, 1);
        check(s_ov == 0, "R2 held beat not sent (2)", s_ov, 0);
        step(1, 1, 8'h77, 0, 1);
        step(0, 0, 0, 0, 1);
        check(s_ov && s_od == 8'hD1, "R4 held beat released by terminator", s_od, 8'hD1);
        check(s_ol == 1, "R4 last set on closing beat", s_ol, 1);

        // ---------- R1: reset mid-stream ----------
        step(1, 0, 8'h10, 0, 0);
        step(1, 0, 8'h11, 0, 0);
        do_reset();
        step(0, 0, 0, 0, 0);
        check(s_ov == 0, "R1 out_valid cleared mid-stream", s_ov, 0);
        check(s_in_rdy == 1, "R1 hold emptied mid-stream", s_in_rdy, 1);

        // ---------- R7 / R8 / R3 / R6: stall with full pipeline ----------
        do_reset();
        step(1, 0, 8'hA0, 1, 0);
        step(1, 0, 8'hA1, 0, 0);
        check(s_in_rdy == 1, "R7 ready with empty output stage", s_in_rdy, 1);
        step(1, 0, 8'hA2, 0, 0);
        check(s_in_rdy == 0, "R7 not ready when both stages full", s_in_rdy, 0);
        check(s_ov && s_od == 8'hA0, "R8 output held during stall", s_od, 8'hA0);
        step(1, 0, 8'hA2, 0, 1);
        check(s_in_rdy == 1, "R7 ready when output drains", s_in_rdy, 1);
        check(s_of == 1 && s_ol == 0, "R6 first carried, no last", {s_of, s_ol}, 2);
        step(1, 1, 8'h00, 0, 1);
        check(s_od == 8'hA1 && s_ol == 0, "R3 data beat sent without last", s_od, 8'hA1);
        step(0, 0, 0, 0, 1);
        check(s_od == 8'hA2 && s_ol == 1 && s_of == 0, "R4 closing beat", {s_od, s_ol}, {8'hA2, 1'b1});

        // ---------- R9: full rate ----------
        do_reset();
        outs = 0; allrdy = 1; lastpos = 0;
        for (int k = 0; k < 12; k++) begin
            if (k < 10)       step(1, 0, 8'(k + 8'h30), k == 0, 1);
            else if (k == 10) step(1, 1, 8'h00, 0, 1);
            else              step(0, 0, 0, 0, 1);
            if (k <= 10 && !s_in_rdy) allrdy = 0;
            if (s_out_acc) begin
                if (s_od != 8'(outs + 8'h30)) allrdy = 0;
                outs++;
                if (k == 11 && s_ol) lastpos = 1;
            end
        end
        check(allrdy, "R9 input ready every cycle and order kept", allrdy, 1);
        check(outs == 10, "R9 one beat per cycle", outs, 10);
        check(lastpos, "R9 last on final cycle", lastpos, 1);

        // ---------- R10 / R3 / R4 / R6 sweep over valid x ready patterns ----------
        for (int vp = 1; vp < 16; vp++) begin
            for (int rp = 1; rp < 16; rp++) begin
                do_reset();
                si = 0; oi = 0; cyc = 0; pst = 0; pd = 0; pf = 0; pl = 0;
                while ((si < ns || oi < ne) && cyc < 400) begin
                    if (si < ns)
                        step(vp[cyc % 4], sc_end[si], sc_data[si], sc_first[si], rp[(cyc + 1) % 4]);
                    else
                        step(0, 0, 0, 0, rp[(cyc + 1) % 4]);
                    if (pst && !(s_ov && s_od == pd && s_of == pf && s_ol == pl))
                        check(0, "R8 stall stability", s_od, pd);
                    if (s_out_acc) begin
                        if (oi < ne)
                            check(s_od == ex_data[oi] && s_of == ex_first[oi] && s_ol == ex_last[oi],
                                  "R10 beat content (R3 R4 R6)",
                                  {s_od, s_of, s_ol}, {ex_data[oi], ex_first[oi], ex_last[oi]});
                        else
                            check(0, "R10 extra output beat", oi, ne);
                        oi++;
                    end
                    pst = s_ov && !(s_out_acc);
                    pd = s_od; pf = s_of; pl = s_ol;
                    if (s_in_acc) si++;
                    cyc++;
                end
                check(si == ns && oi == ne, "R10 all beats moved", oi, ne);
                step(0, 0, 0, 0, 1);
                step(0, 0, 0, 0, 1);
                check(s_ov == 0, "R5 nothing after final terminator", s_ov, 0);
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule